// File: doc/BRIEF.md
# Variable-pulse-width symbol receiver

This block sits behind the receive comparator of a single-wire, variable-pulse-width serial bus. It takes the bus level as one bit (1 = active/dominant, 0 = passive) and measures, in ticks of its own clock, how long each active and each passive period lasts. When a period ends, it reports which symbol that period stands for.

The input goes through a two-flop synchroniser and then a deglitch filter. A level change counts only after it has been seen for `GLITCH` consecutive ticks. A single counter measures the time between accepted transitions. On each accepted transition the length of the period that just ended is compared with four tick boundaries. Adjacent windows meet at a shared boundary with no gap between them, so each count maps to exactly one symbol. The meaning of a window depends on the level of the period: a short passive period is a 0 but a short active period is a 1. A passive stretch longer than `T_IDLE` ticks is reported as idle once, while it is still in progress.

Downstream logic (byte assembly, CRC, arbitration) consumes the one-cycle strobe and the 3-bit code.

Top module: `vpw_sym_rx`

## Requirements
- R1: After synchronous reset the block is in the idle state with `sym_valid` low. The first accepted active transition after reset produces no strobe.
- R2: A passive period of N ticks that is not idle is classified as follows: N < 34 gives invalid (code 0), 34..95 gives bit 0 (code 1), 96..162 gives bit 1 (code 2), and 163..300 gives end-of-data (code 3).
- R3: An active period of N ticks is classified as follows: N < 34 gives invalid (code 0), 34..95 gives bit 1 (code 2), 96..162 gives bit 0 (code 1), 163..238 gives start-of-frame (code 4), and N ≥ 239 gives break (code 5).
- R4: Every boundary belongs to the upper window. Counts of 33, 95, 162 and 238 fall in the lower class; counts of 34, 96, 163 and 239 fall in the upper class.
- R5: A passive period longer than 300 ticks emits idle (code 6) exactly once. The strobe comes 300 ticks after the transition into passive was accepted. The active transition that ends such a period emits nothing.
- R6: A pulse of the opposite level that lasts fewer than `GLITCH` (default 3) ticks is ignored. It causes no strobe and does not change the measured length of the period around it.
- R7: Each strobe lasts one clock. For a transition first sampled at clock edge n, the strobe for the period that just ended is high after edge n+GLITCH+1. Outside scheduled symbols `sym_valid` stays low.
- R8: The width counter saturates. An active period of any length beyond 238 ticks, including lengths well above 300, reports break.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; one tick of pulse-width resolution |
| rst | input | 1 | Synchronous active-high reset |
| bus_in | input | 1 | Digitised bus level, 1 = active, asynchronous to clk |
| sym_valid | output | 1 | One-cycle strobe: a symbol has been classified |
| sym_code | output | 3 | Symbol code, valid while sym_valid is high |

## Verification
The assertions assume `bus_in` pulses are either shorter than `GLITCH` ticks (treated as noise) or at least that long. They also assume that, whenever a genuine period is accepted, its deglitched transitions are at least `GLITCH` ticks apart, so two strobes can never land on neighbouring cycles. The stimulus builds every frame from whole periods of at least 20 ticks, and places its deliberate glitches of `GLITCH`-1 ticks well inside longer periods. The reference model in the bench schedules each expected strobe from the period lengths it drove, and compares the outputs against that schedule on every clock.

// File: rtl/vpw_sym_rx.sv
module vpw_sym_rx #(
  parameter int T_SHORT = 34,
  parameter int T_MID   = 96,
  parameter int T_LONG  = 163,
  parameter int T_BRK   = 239,
  parameter int T_IDLE  = 300,
  parameter int GLITCH  = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_in,
  output logic       sym_valid,
  output logic [2:0] sym_code
);

  localparam int CW = $clog2(T_IDLE + 2);
  localparam int SW = $clog2(GLITCH + 1);
  localparam logic [CW-1:0] SAT   = CW'(T_IDLE + 1);
  localparam logic [CW-1:0] B_SH  = CW'(T_SHORT);
  localparam logic [CW-1:0] B_MID = CW'(T_MID);
  localparam logic [CW-1:0] B_LG  = CW'(T_LONG);
  localparam logic [CW-1:0] B_BRK = CW'(T_BRK);
  localparam logic [CW-1:0] B_IDL = CW'(T_IDLE);
  localparam logic [SW-1:0] STAB_LAST = SW'(GLITCH - 1);

  localparam logic [2:0] C_INV  = 3'd0;
  localparam logic [2:0] C_ZERO = 3'd1;
  localparam logic [2:0] C_ONE  = 3'd2;
  localparam logic [2:0] C_EOD  = 3'd3;
  localparam logic [2:0] C_SOF  = 3'd4;
  localparam logic [2:0] C_BRK  = 3'd5;
  localparam logic [2:0] C_IDLE = 3'd6;

  logic          s1, s2, lvl;
  logic [SW-1:0] stab;
  logic [CW-1:0] cnt;
  logic [2:0]    cls;

  wire flip     = (s2 != lvl) && (stab == STAB_LAST);
  wire idle_hit = !lvl && !flip && (cnt == B_IDL);
  wire report   = flip && (lvl || cnt <= B_IDL);

  always_comb begin
    if (cnt < B_SH)        cls = C_INV;
    else if (cnt < B_MID)  cls = lvl ? C_ONE : C_ZERO;
    else if (cnt < B_LG)   cls = lvl ? C_ZERO : C_ONE;
    else if (!lvl)         cls = C_EOD;
    else if (cnt < B_BRK)  cls = C_SOF;
    else                   cls = C_BRK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= bus_in;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl  <= 1'b0;
      stab <= '0;
    end else if (s2 == lvl) begin
      stab <= '0;
    end else if (flip) begin
      lvl  <= s2;
      stab <= '0;
    end else begin
      stab <= stab + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             cnt <= SAT;
    else if (flip)       cnt <= CW'(1);
    else if (cnt != SAT) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sym_valid <= 1'b0;
      sym_code  <= C_INV;
    end else begin
      sym_valid <= report || idle_hit;
      if (report)        sym_code <= cls;
      else if (idle_hit) sym_code <= C_IDLE;
    end
  end

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    sym_valid |=> !sym_valid); // R7

  AST_LEVEL_AFTER_FILTER: assert property (@(posedge clk) disable iff (rst)
    !$stable(lvl) |-> ($past(stab) == STAB_LAST && $past(s2) == lvl)); // R6

  AST_EDGE_STROBE: assert property (@(posedge clk) disable iff (rst)
    (!$stable(lvl) && ($past(lvl) || $past(cnt) <= B_IDL)) |-> sym_valid); // R2

  AST_IDLE_WHILE_PASSIVE: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && sym_code == C_IDLE) |-> (!lvl && $stable(lvl))); // R5

  AST_SOF_FROM_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && (sym_code == C_SOF || sym_code == C_BRK)) |-> ($past(lvl) && !lvl)); // R3

  AST_EOD_FROM_PASSIVE: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && sym_code == C_EOD) |-> (!$past(lvl) && lvl)); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt <= SAT); // R8

  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
    sym_valid |-> sym_code != 3'd7); // R3

endmodule

// File: tb/vpw_sym_rx_test.sv
module vpw_sym_rx_test;
  localparam int GLITCH = 3;
  localparam int LAT    = GLITCH + 1;
  localparam int IDLE_T = 300;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_in = 1'b0;
  logic sym_valid;
  logic [2:0] sym_code;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit live = 1'b0;
  int    exp_code [int];
  string exp_tag  [int];

  vpw_sym_rx #(.GLITCH(GLITCH)) uut (
    .clk(clk), .rst(rst), .bus_in(bus_in),
    .sym_valid(sym_valid), .sym_code(sym_code)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int classify(input bit lv, input int n);
    if (n < 34) return 0;
    if (n < 96) return lv ? 2 : 1;
    if (n < 163) return lv ? 1 : 2;
    if (!lv) return 3;
    if (n < 239) return 4;
    return 5;
  endfunction

  // One period of level lv lasting len ticks, with an optional short
  // opposite pulse of glen ticks starting gat ticks in (R6).
  task automatic seg(input bit lv, input int len, input string tag,
                     input int gat = 0, input int glen = 0);
    int s;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      bus_in = lv ^ (glen > 0 && i >= gat && i < gat + glen);
      if (i == 0) begin
        s = cyc + 1;
        if (!(lv == 1'b0 && len > IDLE_T)) begin
          exp_code[s + LAT + len] = classify(lv, len);
          exp_tag[s + LAT + len]  = tag;
        end
        if (lv == 1'b0 && len > IDLE_T) begin
          exp_code[s + LAT + IDLE_T] = 6;
          exp_tag[s + LAT + IDLE_T]  = "R5";
        end
      end
    end
  endtask

  // Cycle-by-cycle comparison (R7 for quiet cycles, R1 during and after reset).
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (exp_code.exists(cyc)) begin
        if (!sym_valid || sym_code != 3'(exp_code[cyc])) begin
          fails++;
          $display("FAIL %s cyc %0d: valid=%0b code=%0d expected valid=1 code=%0d",
                   exp_tag[cyc], cyc, sym_valid, sym_code, exp_code[cyc]);
        end
      end else if (sym_valid) begin
        fails++;
        $display("FAIL %s cyc %0d: valid=1 code=%0d expected valid=0",
                 live ? "R7" : "R1", cyc, sym_code);
      end
      if (cyc > 150000) begin
        fails++;
        $display("FAIL watchdog: cyc=%0d expected completion", cyc);
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    live = 1'b1;
    // R1: first active edge out of reset idle gives no strobe
    seg(1, 200, "R3");
    seg(0, 64,  "R2");
    seg(1, 64,  "R3");
    seg(0, 128, "R2");
    seg(1, 128, "R3");
    seg(0, 33,  "R4");
    seg(1, 34,  "R4");
    seg(0, 95,  "R4");
    seg(1, 95,  "R4");
    seg(0, 96,  "R4");
    seg(1, 96,  "R4");
    seg(0, 162, "R4");
    seg(1, 162, "R4");
    seg(0, 163, "R4");
    seg(1, 163, "R4");
    seg(0, 300, "R2");
    seg(1, 238, "R4");
    seg(0, 301, "R5");
    seg(1, 239, "R4");
    seg(0, 200, "R6", 50, GLITCH - 1);
    seg(1, 20,  "R3");
    seg(0, 34,  "R2");
    seg(1, 100, "R6", 30, GLITCH - 1);
    seg(0, 40,  "R2");
    seg(1, 400, "R8");
    seg(0, 500, "R5");
    seg(1, 170, "R3");
    seg(0, 350, "R5");
    repeat (20) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule